// File: doc/BRIEF.md
# Sequential Non-Restoring Unsigned Divider

This block divides an unsigned W-bit dividend by an unsigned W-bit divisor and returns a W-bit quotient and a W-bit remainder. It works one quotient bit per clock and never restores the partial remainder during the iterations. In each step it adds the divisor or subtracts it, depending on the sign of the partial remainder. After the last step it runs one correction step, which makes a negative remainder non-negative again. The partial remainder is kept one bit wider than the operands, and its top bit is the sign.

A caller pulses `start_i` with both operands valid. The block raises `busy_o` while it works and pulses `done_o` for one cycle once the results are on the outputs. A zero divisor skips the iterations and gives an error flag instead. One flag marks the indeterminate case, where the dividend is also zero. The other flag marks a nonzero value divided by zero.

Top module: `nr_divider`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it is released, `busy_o`, `done_o`, `err_indet_o` and `err_inf_o` are 0, and `quotient_o` and `remainder_o` are 0. A reset in the middle of a division ends it.
- R2: `start_i` is sampled on a rising edge while the block is idle and the divisor is nonzero. In that case `busy_o` is 1 from the next cycle for W+1 cycles: W iterations and then one correction cycle. `done_o` stays 0 during those cycles.
- R3: For every nonzero divisor, in the cycle where `done_o` is 1 the outputs meet `dividend = quotient_o*divisor + remainder_o` with `remainder_o < divisor`, and `busy_o` is 0.
- R4: A start with dividend 0 and divisor 0 makes `done_o` and `err_indet_o` 1 in the next cycle, with `err_inf_o` at 0. `quotient_o` and `remainder_o` become 0, and `busy_o` never rises.
- R5: A start with a nonzero dividend and divisor 0 makes `done_o` and `err_inf_o` 1 in the next cycle, with `err_indet_o` at 0. `quotient_o` and `remainder_o` become 0, and `busy_o` never rises.
- R6: A `start_i` pulse while `busy_o` is 1 is ignored. The running division finishes on its original schedule with the operands that were captured first.
- R7: `done_o` is high for exactly one cycle. The error flags are high only together with `done_o`.
- R8: After `done_o`, `quotient_o` and `remainder_o` hold their values until the next accepted start.
- R9: A start given in the cycle where `done_o` is 1 is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a division when the block is idle |
| dividend_i | input | W | Unsigned dividend, sampled with start |
| divisor_i | input | W | Unsigned divisor, sampled with start |
| quotient_o | output | W | Quotient result |
| remainder_o | output | W | Remainder result |
| done_o | output | 1 | One-cycle pulse: results or error are valid |
| busy_o | output | 1 | Division in progress |
| err_indet_o | output | 1 | Pulse with done for 0/0 |
| err_inf_o | output | 1 | Pulse with done for a nonzero value divided by 0 |

## Verification
The assertions assume two things about the inputs:
- The operands only matter on the edge where a start is accepted.
- The divisor captured with a start never changes during an iteration. The remainder bound checked at done depends on this.

The stimulus drives operands and `start_i` only on falling edges. It does not lower `rst_ni` except in the reset tests. It keeps operands within W bits. A start issued while busy is driven on purpose, so that the rule to ignore it is exercised without breaking these assumptions.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ITER = 2'd1,
    ST_FIX  = 2'd2
  } state_e;
endpackage

// File: rtl/nrdiv_step.sv
module nrdiv_step #(
  parameter int W = 4
) (
  input  logic [W:0]   rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] div_i,
  output logic [W:0]   rem_o,
  output logic [W-1:0] quo_o
);
  logic [W:0] dext;
  logic [W:0] shifted;

  always_comb begin
    dext    = {1'b0, div_i};
    shifted = {rem_i[W-1:0], quo_i[W-1]};
    // sign of the pre-shift remainder picks add or subtract; wrap is harmless mod 2^(W+1)
    rem_o   = rem_i[W] ? (shifted + dext) : (shifted - dext);
    quo_o   = {quo_i[W-2:0], ~rem_o[W]};
  end
endmodule

// File: rtl/nrdiv_fix.sv
module nrdiv_fix #(
  parameter int W = 4
) (
  input  logic [W:0]   rem_i,
  input  logic [W-1:0] div_i,
  output logic [W:0]   rem_o
);
  always_comb begin
    rem_o = rem_i[W] ? (rem_i + {1'b0, div_i}) : rem_i;
  end
endmodule

// File: rtl/nrdiv_ctrl.sv
module nrdiv_ctrl #(
  parameter int W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic div_zero_i,
  input  logic dvd_zero_i,
  output logic load_o,
  output logic clr_o,
  output logic iter_o,
  output logic fix_o,
  output logic busy_o,
  output logic done_o,
  output logic err_indet_o,
  output logic err_inf_o
);
  import nrdiv_pkg::*;

  localparam int CW = $clog2(W + 1);

  state_e        state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          accept;

  assign accept = start_i && (state_q == ST_IDLE);
  assign load_o = accept && !div_zero_i;
  assign clr_o  = accept && div_zero_i;
  assign iter_o = (state_q == ST_ITER);
  assign fix_o  = (state_q == ST_FIX);
  assign busy_o = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (load_o) begin
        state_d = ST_ITER;
        cnt_d   = CW'(W);
      end
      ST_ITER: begin
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == CW'(1)) state_d = ST_FIX;
      end
      ST_FIX:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      done_o      <= 1'b0;
      err_indet_o <= 1'b0;
      err_inf_o   <= 1'b0;
    end else begin
      state_q     <= state_d;
      cnt_q       <= cnt_d;
      done_o      <= fix_o || clr_o;
      err_indet_o <= clr_o && dvd_zero_i;
      err_inf_o   <= clr_o && !dvd_zero_i;
    end
  end

  p_busy_after_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !div_zero_i) |=> busy_o);
  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iter_o |-> (cnt_q != '0) && (cnt_q <= CW'(W)));
  p_no_busy_on_err_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |=> (!busy_o && done_o));
  p_err_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_indet_o && err_inf_o));
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_err_with_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_indet_o || err_inf_o) |-> done_o);
  p_busy_start_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iter_o && start_i && cnt_q != CW'(1)) |=> iter_o);
endmodule

// File: rtl/nr_divider.sv
module nr_divider #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] quotient_o,
  output logic [W-1:0] remainder_o,
  output logic         done_o,
  output logic         busy_o,
  output logic         err_indet_o,
  output logic         err_inf_o
);
  logic [W:0]   rem_q, rem_step, rem_fix;
  logic [W-1:0] quo_q, quo_step, div_q;
  logic         load, clr, iter, fix;

  nrdiv_ctrl #(.W(W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .div_zero_i  (divisor_i == '0),
    .dvd_zero_i  (dividend_i == '0),
    .load_o      (load),
    .clr_o       (clr),
    .iter_o      (iter),
    .fix_o       (fix),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_indet_o (err_indet_o),
    .err_inf_o   (err_inf_o)
  );

  nrdiv_step #(.W(W)) u_step (
    .rem_i (rem_q),
    .quo_i (quo_q),
    .div_i (div_q),
    .rem_o (rem_step),
    .quo_o (quo_step)
  );

  nrdiv_fix #(.W(W)) u_fix (
    .rem_i (rem_q),
    .div_i (div_q),
    .rem_o (rem_fix)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      quo_q <= '0;
      div_q <= '0;
    end else if (clr) begin
      rem_q <= '0;
      quo_q <= '0;
    end else if (load) begin
      rem_q <= '0;
      quo_q <= dividend_i;
      div_q <= divisor_i;
    end else if (iter) begin
      rem_q <= rem_step;
      quo_q <= quo_step;
    end else if (fix) begin
      rem_q <= rem_fix;
    end
  end

  assign quotient_o  = quo_q;
  assign remainder_o = rem_q[W-1:0];

  p_rem_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_indet_o && !err_inf_o) |-> (!rem_q[W] && (rem_q[W-1:0] < div_q)));
  p_err_zero_out_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_indet_o || err_inf_o) |-> (quotient_o == '0 && remainder_o == '0));
  p_hold_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(quotient_o) && $stable(remainder_o)));
  p_done_not_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: tb/nr_divider_tb.sv
module nr_divider_tb;
  localparam int W = 4;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {dividend, divisor, quotient, remainder}
  localparam logic [4*W-1:0] VEC [NVEC] = '{
    {4'd15, 4'd1,  4'd15, 4'd0},
    {4'd15, 4'd15, 4'd1,  4'd0},
    {4'd9,  4'd4,  4'd2,  4'd1},
    {4'd7,  4'd8,  4'd0,  4'd7},
    {4'd0,  4'd5,  4'd0,  4'd0},
    {4'd14, 4'd3,  4'd4,  4'd2},
    {4'd8,  4'd2,  4'd4,  4'd0},
    {4'd13, 4'd7,  4'd1,  4'd6}
  };

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [W-1:0] dividend_i = '0;
  logic [W-1:0] divisor_i = '0;
  logic [W-1:0] quotient_o, remainder_o;
  logic         done_o, busy_o, err_indet_o, err_inf_o;

  int n_checks = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  nr_divider #(.W(W)) u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .dividend_i  (dividend_i),
    .divisor_i   (divisor_i),
    .quotient_o  (quotient_o),
    .remainder_o (remainder_o),
    .done_o      (done_o),
    .busy_o      (busy_o),
    .err_indet_o (err_indet_o),
    .err_inf_o   (err_inf_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [W-1:0] eq, input logic [W-1:0] er);
    @(negedge clk_i);
    start_i = 1'b1; dividend_i = a; divisor_i = b;
    @(negedge clk_i);
    start_i = 1'b0;
    if (b == '0) begin
      check(done_o == 1'b1, "R4/R5 done", done_o, 1);
      check(err_indet_o == (a == '0), "R4 indet flag", err_indet_o, a == '0);
      check(err_inf_o == (a != '0), "R5 inf flag", err_inf_o, a != '0);
      check(busy_o == 1'b0, "R4 busy", busy_o, 0);
      check(quotient_o == '0 && remainder_o == '0, "R5 zero outputs", {quotient_o, remainder_o}, 0);
      @(negedge clk_i);
      check(!done_o && !err_indet_o && !err_inf_o, "R7 flags drop",
            {done_o, err_indet_o, err_inf_o}, 0);
      check(busy_o == 1'b0, "R4 busy later", busy_o, 0);
    end else begin
      check(busy_o == 1'b1 && done_o == 1'b0, "R2 busy after start", {busy_o, done_o}, 2);
      for (int k = 1; k <= W; k++) begin
        @(negedge clk_i);
        check(busy_o == 1'b1 && done_o == 1'b0, "R2 busy window", {busy_o, done_o}, 2);
      end
      @(negedge clk_i);
      check(done_o == 1'b1 && busy_o == 1'b0, "R3 done timing", {busy_o, done_o}, 1);
      check(quotient_o == eq, "R3 quotient", quotient_o, eq);
      check(remainder_o == er, "R3 remainder", remainder_o, er);
      check(!err_indet_o && !err_inf_o, "R7 no error", {err_indet_o, err_inf_o}, 0);
      @(negedge clk_i);
      check(done_o == 1'b0, "R7 done one cycle", done_o, 0);
      check(quotient_o == eq && remainder_o == er, "R8 hold", {quotient_o, remainder_o}, {eq, er});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_checks++;
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk_i);
    check(!busy_o && !done_o && !err_indet_o && !err_inf_o, "R1 flags in reset",
          {busy_o, done_o, err_indet_o, err_inf_o}, 0);
    check(quotient_o == '0 && remainder_o == '0, "R1 results in reset", {quotient_o, remainder_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o && !done_o, "R1 after release", {busy_o, done_o}, 0);

    // table of directed vectors
    for (int i = 0; i < NVEC; i++)
      run_div(VEC[i][4*W-1:3*W], VEC[i][3*W-1:2*W], VEC[i][2*W-1:W], VEC[i][W-1:0]);

    // error cases
    run_div(4'd0, 4'd0, 4'd0, 4'd0);
    run_div(4'd9, 4'd0, 4'd0, 4'd0);
    run_div(4'd15, 4'd0, 4'd0, 4'd0);

    // R6: start while busy is ignored
    @(negedge clk_i);
    start_i = 1'b1; dividend_i = 4'd13; divisor_i = 4'd3;
    @(negedge clk_i);
    dividend_i = 4'd2; divisor_i = 4'd1;
    repeat (3) @(negedge clk_i);
    start_i = 1'b0;
    repeat (2) @(negedge clk_i);
    check(done_o == 1'b1, "R6 schedule kept", done_o, 1);
    check(quotient_o == 4'd4 && remainder_o == 4'd1, "R6 original operands",
          {quotient_o, remainder_o}, {4'd4, 4'd1});

    // R9: start in the done cycle
    @(negedge clk_i);
    start_i = 1'b1; dividend_i = 4'd11; divisor_i = 4'd2;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (W + 1) @(negedge clk_i);
    check(done_o == 1'b1 && quotient_o == 4'd5 && remainder_o == 4'd1, "R9 first result",
          {done_o, quotient_o, remainder_o}, {1'b1, 4'd5, 4'd1});
    start_i = 1'b1; dividend_i = 4'd6; divisor_i = 4'd4;
    @(negedge clk_i);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R9 accepted at once", busy_o, 1);
    repeat (W + 1) @(negedge clk_i);
    check(done_o == 1'b1 && quotient_o == 4'd1 && remainder_o == 4'd2, "R9 second result",
          {done_o, quotient_o, remainder_o}, {1'b1, 4'd1, 4'd2});

    // R1: reset mid-division
    @(negedge clk_i);
    start_i = 1'b1; dividend_i = 4'd12; divisor_i = 4'd5;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check(!busy_o && !done_o && quotient_o == '0 && remainder_o == '0, "R1 mid-run reset",
          {busy_o, done_o, quotient_o, remainder_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R3: exhaustive sweep of all operand pairs
    for (int a = 0; a < (1 << W); a++)
      for (int b = 0; b < (1 << W); b++)
        if (b != 0) run_div(W'(a), W'(b), W'(a / b), W'(a % b));
        else        run_div(W'(a), W'(b), '0, '0);

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule